// File: doc/BRIEF.md
# Memory-Backed Event Counter Bank

This block keeps one event count for each of many input channels. The counts live in a behavioural dual-port memory, not in a register array. Each clock can carry one event, given as a valid bit and a channel index. The block reads that channel's count from memory, adds one in its own registered stage, and writes the sum back. If an event lands on a channel whose update is still in the pipeline, the newer in-flight value is fed to the adder in place of the stale memory word. Every event is therefore counted, even when events arrive on consecutive cycles. Counts stop at their largest value and do not wrap.

A clear request starts a sweep that writes zero to one address per cycle. The sweep holds `busy` high and drops events for its whole length. A separate host read port returns any channel's count two cycles after the index is presented. That port only reads, so it never stalls or corrupts an update. Reset returns the pipeline and the sweep control to idle and leaves the memory contents alone.

Top module: `evcnt_ram`

## Requirements
- R1: After synchronous active-high reset, `busy` is low and `rd_data` is zero.
- R2: An event with `ev_valid` high raises the count of channel `ev_chan` by exactly one. The new value can be read from the host port once the event's clock edge is three or more edges in the past.
- R3: The host port samples `rd_chan` at clock edge k. `rd_data` shows that channel's count, as committed before edge k, from edge k+1 onward, one edge after the index register and two edges in total. Before that, `rd_data` keeps its previous value.
- R4: Events on the same channel in consecutive cycles are all counted.
- R5: Events on the same channel two cycles apart are all counted, including when a write-back and a new read of that channel fall on the same edge.
- R6: Events on different channels, interleaved cycle by cycle, update only their own channel's count.
- R7: A count that has reached 2^CNT_W-1 stays there on further events. It never wraps to zero.
- R8: When `clr_req` is sampled high while `busy` is low, `busy` rises at the next edge and stays high for exactly CHANNELS cycles.
- R9: After a clear sweep, every channel reads zero.
- R10: Events presented while `busy` is high, or in the cycle `clr_req` starts a sweep, have no effect on any count.
- R11: Reset does not change the stored counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the control state |
| ev_valid | input | 1 | An event is present this cycle |
| ev_chan | input | IDX_W | Channel of the event |
| clr_req | input | 1 | Start a zeroing sweep |
| busy | output | 1 | Sweep in progress; events are dropped |
| rd_chan | input | IDX_W | Channel to read on the host port |
| rd_data | output | CNT_W | Count of the requested channel, two cycles later |

## Verification
The bench hits one channel with bursts in which events are zero, one, two and three cycles apart. A design that forwards only from the adder stage, or that never forwards, loses counts on the one-cycle gap, because there the write-back and the re-read of the same word fall on the same edge. Interleaved traffic on two channels catches a forwarding compare that ignores the channel index, which would show up as counts moving between neighbours. Further tests drive a count past its maximum to catch wrapping, and send events during a sweep to catch a sweep that lets events through or runs one cycle long or short. A read switched between channels pins down the two-cycle read latency. A reset in the middle of the run must leave the stored counts in place.

// File: rtl/evcnt_ram.sv
module evcnt_ram #(
  parameter int CHANNELS = 128,
  parameter int CNT_W    = 24,
  localparam int IDX_W   = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_chan,
  input  logic             clr_req,
  output logic             busy,
  input  logic [IDX_W-1:0] rd_chan,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHANNELS - 1);

  logic [CNT_W-1:0] mem [CHANNELS];

  logic             s1_v, s2_v, s3_v;
  logic [IDX_W-1:0] s1_ch, s2_ch, s3_ch;
  logic [CNT_W-1:0] s1_q, s2_sum, s3_sum;
  logic [CNT_W-1:0] op, nxt;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] rd_q;
  logic             start;

  assign start = clr_req & ~busy;

  assign op  = (s2_v && s2_ch == s1_ch) ? s2_sum :
               (s3_v && s3_ch == s1_ch) ? s3_sum : s1_q;
  assign nxt = (op == TOP) ? TOP : op + 1'b1;

  always_ff @(posedge clk) begin
    if (busy) mem[ptr] <= '0;
    else if (s2_v) mem[s2_ch] <= s2_sum;
    s1_q <= mem[ev_chan];
    rd_q <= mem[rd_chan];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      busy <= 1'b0;
      ptr  <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_q;
      s1_v <= ev_valid & ~busy & ~start;
      s2_v <= s1_v & ~start & ~busy;
      s3_v <= s2_v & ~start & ~busy;
      if (start) begin
        busy <= 1'b1;
        ptr  <= '0;
      end else if (busy) begin
        ptr <= ptr + 1'b1;
        if (ptr == LAST) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    s1_ch  <= ev_chan;
    s2_ch  <= s1_ch;
    s2_sum <= nxt;
    s3_ch  <= s2_ch;
    s3_sum <= s2_sum;
  end
endmodule

module evcnt_ram_chk #(
  parameter int CHANNELS = 128,
  parameter int CNT_W    = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_req,
  input logic             busy,
  input logic             s1_v,
  input logic             s2_v,
  input logic [CNT_W-1:0] s2_sum
);
  int unsigned bcnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= 0;
    else bcnt <= bcnt + 1;
  end

  // R8
  sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !busy) |=> busy);

  // R8
  sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(bcnt) == CHANNELS - 1);

  // R10
  drop_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !s1_v);

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> s2_sum != '0);
endmodule

bind evcnt_ram evcnt_ram_chk #(.CHANNELS(CHANNELS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr_req(clr_req), .busy(busy),
  .s1_v(s1_v), .s2_v(s2_v), .s2_sum(s2_sum)
);

// File: tb/sim_evcnt_ram.sv
module sim_evcnt_ram;
  localparam int CH = 128;
  localparam int IW = $clog2(CH);
  localparam int TW = 10;
  localparam int TOPV = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [IW-1:0] ev_chan = '0;
  logic clr_req = 1'b0;
  logic busy;
  logic [IW-1:0] rd_chan = '0;
  logic [TW-1:0] rd_data;

  int runs = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evcnt_ram #(.CHANNELS(CH), .CNT_W(TW)) u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .clr_req(clr_req), .busy(busy), .rd_chan(rd_chan), .rd_data(rd_data)
  );

  localparam int NT = 6;
  localparam int T_CH [NT]  = '{3, 3, 127, 0, 3, 64};
  localparam int T_N  [NT]  = '{5, 4, 3, 7, 1, 2};
  localparam int T_GAP[NT]  = '{0, 1, 2, 0, 0, 3};
  localparam int T_EXP[NT]  = '{5, 9, 3, 7, 10, 2};

  task automatic chk(input string tag, input int got, input int exp);
    runs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send(input int ch, input int gap);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_chan = IW'(ch);
    repeat (gap) begin
      @(negedge clk);
      ev_valid = 1'b0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    ev_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readch(input int ch, output int val);
    @(negedge clk);
    rd_chan = IW'(ch);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic sweep(input bit with_events, output int bcycles);
    @(negedge clk);
    clr_req = 1'b1;
    ev_valid = with_events;
    ev_chan = IW'(3);
    @(negedge clk);
    clr_req = 1'b0;
    bcycles = 0;
    while (busy && bcycles < 1000) begin
      bcycles++;
      @(negedge clk);
    end
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      runs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    int v, bc, v0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);

    sweep(1'b0, bc);
    chk("R8 sweep length", bc, CH);

    for (int i = 0; i < NT; i++) begin
      for (int k = 0; k < T_N[i]; k++) send(T_CH[i], T_GAP[i]);
      drain();
      readch(T_CH[i], v);
      chk($sformatf("R2/R4/R5 table row %0d", i), v, T_EXP[i]);
    end

    for (int k = 0; k < 6; k++) begin
      send(10, 0);
      send(11, 0);
    end
    drain();
    readch(10, v);
    chk("R6 interleaved ch10", v, 6);
    readch(11, v);
    chk("R6 interleaved ch11", v, 6);
    readch(3, v);
    chk("R6 untouched ch3", v, 10);

    readch(0, v0);
    @(negedge clk);
    rd_chan = IW'(3);
    @(posedge clk);
    @(negedge clk);
    chk("R3 old value held after one edge", int'(rd_data), v0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 new value after two edges", int'(rd_data), 10);

    for (int k = 0; k < TOPV + 6; k++) send(20, 0);
    drain();
    readch(20, v);
    chk("R7 saturated count", v, TOPV);
    send(20, 0);
    drain();
    readch(20, v);
    chk("R7 stays at maximum", v, TOPV);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    readch(3, v);
    chk("R11 count kept over reset", v, 10);
    readch(20, v);
    chk("R11 saturated kept over reset", v, TOPV);

    sweep(1'b1, bc);
    chk("R8 second sweep length", bc, CH);
    readch(3, v);
    chk("R10 events during sweep dropped", v, 0);

    for (int c = 0; c < CH; c++) begin
      readch(c, v);
      chk($sformatf("R9 ch%0d zero after clear", c), v, 0);
    end

    send(5, 0);
    drain();
    readch(5, v);
    chk("R2 single event after clear", v, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule